// File: doc/BRIEF.md
# Programmable-Ratio I/Q Interpolation Chain

This block raises the sample rate of a complex baseband stream so that it matches a converter clock. Each clock cycle it delivers one I/Q pair. It pulls a new input pair once every R clocks, where R is an interpolation ratio that can be changed at run time. The path has up to two half-band interpolators, each doubling the rate, followed by a four-stage cascaded integrator-comb (CIC) interpolator that supplies the rest of the ratio.

The two low bits of R decide how the path is built:
- An odd ratio sends samples straight into the CIC.
- A ratio that is two more than a multiple of four inserts the long (31-tap) half-band.
- A multiple of four inserts both the long half-band and the short (7-tap) half-band. The short one runs at the higher of the two rates.

A right shift that follows the ratio keeps the overall DC gain between one half and one.

If the source has no sample ready when one is requested, the chain takes zero instead and raises a one-cycle flag. Writing a new ratio flushes all filter history, so samples from the old configuration never mix with the new one.

Top module: `duc_interp_chain`

## Requirements
- R1: `in_ready` is high for exactly one cycle and recurs every R clocks, where R is the effective ratio.
- R2: A requested ratio below 4 acts as 4, and one above 512 acts as 512.
- R3: When R is odd, no half-band is used and the CIC interpolates by Rc = R.
- R4: When R mod 4 = 2, only the 31-tap half-band is used and the CIC interpolates by Rc = R/2.
- R5: When R mod 4 = 0, both half-bands are used, the 31-tap one ahead of the 7-tap one, and the CIC interpolates by Rc = R/4.
- R6: For a constant input x on a lane, that lane's output settles to floor(x·Rc³ / 2^s), saturated to 16 bits signed. Here s is the smallest integer with 2^s ≥ Rc³. The I and Q lanes are independent.
- R7: A cycle with `in_ready` high and `in_valid` low consumes a zero sample, and `underrun` is high in the following cycle only. In every other cycle `underrun` is low.
- R8: A change of the effective ratio clears all filter state. Both outputs read zero in the cycle after the change, and `in_ready` stays low during the change cycle.
- R9: During reset both outputs are zero and `underrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio | input | 10 | Requested interpolation ratio |
| in_valid | input | 1 | An input pair is available |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| in_ready | output | 1 | Input pair is taken this cycle |
| underrun | output | 1 | A zero was substituted in the previous cycle |
| out_i | output | 16 | Output in-phase sample, signed |
| out_q | output | 16 | Output quadrature sample, signed |

## Verification
The assertions assume that `ratio` changes only between clock edges and then stays put long enough for at least one `in_ready` pulse. The spacing check restarts its count on every change, and a ratio that keeps changing would only ever be tested in its flush cycles. The stimulus holds every ratio for many input periods and changes ratio, data and `in_valid` only at the falling edge. It keeps the input amplitude well inside 16 bits, so the half-band overshoot never reaches the guard bits of the internal sample word.

// File: rtl/duc_pkg.sv
package duc_pkg;

    typedef enum logic [1:0] {
        HB_NONE = 2'd0,
        HB_LOW  = 2'd1,
        HB_BOTH = 2'd2
    } hb_mode_e;

    localparam int COEF_W = 17;

    // Odd-phase coefficients of the half-band lines, index 0 is the outermost pair.
    function automatic logic signed [COEF_W-1:0] hb_coef(input int len, input int k);
        logic signed [COEF_W-1:0] c;
        c = '0;
        if (len == 16) begin
            case (k)
                0: c = -17'sd13;
                1: c = 17'sd138;
                2: c = -17'sd419;
                3: c = 17'sd930;
                4: c = -17'sd1781;
                5: c = 17'sd3248;
                6: c = -17'sd6359;
                7: c = 17'sd20640;
                default: c = '0;
            endcase
        end else begin
            case (k)
                0: c = -17'sd1;
                1: c = 17'sd9;
                default: c = '0;
            endcase
        end
        return c;
    endfunction

    // The odd-phase coefficients sum to 2**norm, so the DC gain of that phase is exactly one.
    function automatic int hb_norm(input int len);
        return (len == 16) ? 15 : 4;
    endfunction

endpackage

// File: rtl/duc_hb_poly.sv
module duc_hb_poly
    import duc_pkg::*;
#(
    parameter int SW  = 19,
    parameter int LEN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic                 phase,
    input  logic signed [SW-1:0] din,
    output logic signed [SW-1:0] dout
);
    localparam int HALF = LEN / 2;
    localparam int NORM = hb_norm(LEN);
    localparam int PW   = SW + COEF_W + $clog2(LEN) + 1;

    typedef struct packed {
        logic [LEN-1:0][SW-1:0] line;
    } hb_state_t;

    hb_state_t st_q, st_d;
    logic signed [PW-1:0] acc;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.line = '0;
        end else if (load) begin
            for (int i = LEN - 1; i > 0; i--) st_d.line[i] = st_q.line[i-1];
            st_d.line[0] = din;
        end

        // Symmetric odd phase: pre-add the mirrored samples, one product per pair.
        acc = '0;
        for (int k = 0; k < HALF; k++) begin
            acc = acc + PW'(hb_coef(LEN, k)) *
                  (PW'(signed'(st_q.line[k])) + PW'(signed'(st_q.line[LEN-1-k])));
        end

        // Even phase is the centre tap: a plain delayed copy of the input.
        dout = phase ? SW'(acc >>> NORM) : signed'(st_q.line[HALF]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/duc_cic.sv
module duc_cic #(
    parameter int IW     = 19,
    parameter int AW     = 59,
    parameter int OW     = 16,
    parameter int SHW    = 5,
    parameter int STAGES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 tick,
    input  logic [SHW-1:0]       shift,
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam logic signed [AW-1:0] OUT_MAX = signed'((AW'(1) << (OW - 1)) - AW'(1));
    localparam logic signed [AW-1:0] OUT_MIN = ~OUT_MAX;

    typedef struct packed {
        logic [STAGES-1:0][AW-1:0] dly;
        logic [STAGES-1:0][AW-1:0] integ;
        logic [OW-1:0]             y;
    } cic_state_t;

    cic_state_t st_q, st_d;
    logic [STAGES:0][AW-1:0] comb_v;
    logic [AW-1:0]           stuffed;
    logic signed [AW-1:0]    scaled;

    always_comb begin
        st_d = st_q;

        // Comb section at the slow rate; modular arithmetic throughout.
        comb_v[0] = AW'(din);
        for (int k = 0; k < STAGES; k++) comb_v[k+1] = comb_v[k] - st_q.dly[k];
        if (tick) begin
            for (int k = 0; k < STAGES; k++) st_d.dly[k] = comb_v[k];
        end

        // Zero-stuffing into a pipelined integrator cascade at the fast rate.
        stuffed = tick ? comb_v[STAGES] : '0;
        st_d.integ[0] = st_q.integ[0] + stuffed;
        for (int k = 1; k < STAGES; k++) st_d.integ[k] = st_q.integ[k] + st_q.integ[k-1];

        scaled = signed'(st_q.integ[STAGES-1]) >>> shift;
        if (scaled > OUT_MAX)      st_d.y = OUT_MAX[OW-1:0];
        else if (scaled < OUT_MIN) st_d.y = OUT_MIN[OW-1:0];
        else                       st_d.y = scaled[OW-1:0];

        if (clear) st_d = '0;
        dout = signed'(st_q.y);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a flush leaves the lane output at zero on the next cycle.
    assert_flush_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (dout == '0))
        else $error("flush did not zero the CIC output");

endmodule

// File: rtl/duc_rate_ctrl.sv
module duc_rate_ctrl
    import duc_pkg::*;
#(
    parameter int RATIO_W   = 10,
    parameter int MIN_RATIO = 4,
    parameter int MAX_RATIO = 512,
    parameter int SHW       = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    output logic               restart,
    output hb_mode_e           mode,
    output logic [SHW-1:0]     shift,
    output logic               cic_tick,
    output logic               lo_load,
    output logic               lo_phase,
    output logic               hi_load,
    output logic               hi_phase,
    output logic               in_ready
);
    localparam int CUBE_W = 3 * RATIO_W;
    localparam int GW     = RATIO_W + 1;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] ccnt;
        logic [1:0]         pcnt;
    } rc_state_t;

    rc_state_t st_q, st_d;
    logic [RATIO_W-1:0] rclamp;
    logic [RATIO_W-1:0] cic_ratio;
    logic [CUBE_W-1:0]  cube;
    logic               tick;

    always_comb begin
        if (ratio < RATIO_W'(MIN_RATIO))      rclamp = RATIO_W'(MIN_RATIO);
        else if (ratio > RATIO_W'(MAX_RATIO)) rclamp = RATIO_W'(MAX_RATIO);
        else                                  rclamp = ratio;
        restart = (rclamp != st_q.ratio);

        if (st_q.ratio[0])      mode = HB_NONE;
        else if (st_q.ratio[1]) mode = HB_LOW;
        else                    mode = HB_BOTH;

        case (mode)
            HB_NONE: cic_ratio = st_q.ratio;
            HB_LOW:  cic_ratio = st_q.ratio >> 1;
            default: cic_ratio = st_q.ratio >> 2;
        endcase

        cube  = CUBE_W'(cic_ratio) * CUBE_W'(cic_ratio) * CUBE_W'(cic_ratio);
        shift = '0;
        for (int b = 0; b < CUBE_W - 1; b++) begin
            if ((CUBE_W'(1) << b) < cube) shift = SHW'(b + 1);
        end

        tick     = (st_q.ccnt == '0) && !restart;
        cic_tick = tick;
        hi_phase = st_q.pcnt[0];
        hi_load  = tick && (mode == HB_BOTH) && !st_q.pcnt[0];
        lo_phase = (mode == HB_BOTH) ? st_q.pcnt[1] : st_q.pcnt[0];
        lo_load  = tick && (((mode == HB_BOTH) && (st_q.pcnt == 2'd0)) ||
                            ((mode == HB_LOW) && !st_q.pcnt[0]));
        in_ready = (mode == HB_NONE) ? tick : lo_load;

        st_d = st_q;
        if (restart) begin
            st_d.ratio = rclamp;
            st_d.ccnt  = '0;
            st_d.pcnt  = '0;
        end else if (st_q.ccnt == cic_ratio - RATIO_W'(1)) begin
            st_d.ccnt = '0;
            st_d.pcnt = st_q.pcnt + 2'd1;
        end else begin
            st_d.ccnt = st_q.ccnt + RATIO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ratio <= RATIO_W'(MIN_RATIO);
        end else begin
            st_q <= st_d;
        end
    end

    // Cycle counter between input strobes, used only by the spacing check.
    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (restart) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (in_ready) begin
            gap_q  <= GW'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // R1: consecutive input strobes sit exactly R clocks apart.
    assert_ready_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && seen_q) |-> (gap_q == {1'b0, st_q.ratio}))
        else $error("input strobe spacing differs from the ratio");

    // R8: no input is taken in the flush cycle.
    assert_no_take_on_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(st_q.ratio) |-> $past(!in_ready))
        else $error("input strobe during a ratio change");

endmodule

// File: rtl/duc_interp_chain.sv
module duc_interp_chain
    import duc_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int RATIO_W    = 10,
    parameter int MIN_RATIO  = 4,
    parameter int MAX_RATIO  = 512,
    parameter int CIC_STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              in_ready,
    output logic              underrun,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);
    localparam int SW    = DATA_W + 3;
    localparam int AW    = SW + CIC_STAGES * RATIO_W;
    localparam int SHW   = $clog2(3 * RATIO_W + 1);
    localparam int LANES = 2;

    typedef struct packed {
        logic underrun;
    } top_state_t;

    top_state_t st_q, st_d;

    logic           restart, cic_tick, lo_load, lo_phase, hi_load, hi_phase;
    hb_mode_e       mode;
    logic [SHW-1:0] shift;
    logic [LANES-1:0][DATA_W-1:0] lane_data;
    logic [LANES-1:0][DATA_W-1:0] lane_out;

    duc_rate_ctrl #(
        .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO), .SHW(SHW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ratio(ratio), .restart(restart), .mode(mode),
        .shift(shift), .cic_tick(cic_tick), .lo_load(lo_load), .lo_phase(lo_phase),
        .hi_load(hi_load), .hi_phase(hi_phase), .in_ready(in_ready)
    );

    assign lane_data[0] = in_i;
    assign lane_data[1] = in_q;

    for (genvar c = 0; c < LANES; c++) begin : g_lane
        logic signed [SW-1:0] lane_in, lo_out, hi_out, cic_in;

        assign lane_in = in_valid ? SW'(signed'(lane_data[c])) : '0;

        duc_hb_poly #(.SW(SW), .LEN(16)) u_hb_lo (
            .clk(clk), .rst_n(rst_n), .clear(restart), .load(lo_load),
            .phase(lo_phase), .din(lane_in), .dout(lo_out)
        );

        duc_hb_poly #(.SW(SW), .LEN(4)) u_hb_hi (
            .clk(clk), .rst_n(rst_n), .clear(restart), .load(hi_load),
            .phase(hi_phase), .din(lo_out), .dout(hi_out)
        );

        always_comb begin
            case (mode)
                HB_NONE: cic_in = lane_in;
                HB_LOW:  cic_in = lo_out;
                default: cic_in = hi_out;
            endcase
        end

        duc_cic #(
            .IW(SW), .AW(AW), .OW(DATA_W), .SHW(SHW), .STAGES(CIC_STAGES)
        ) u_cic (
            .clk(clk), .rst_n(rst_n), .clear(restart), .tick(cic_tick),
            .shift(shift), .din(cic_in), .dout(lane_out[c])
        );
    end

    assign out_i = lane_out[0];
    assign out_q = lane_out[1];

    always_comb begin
        st_d          = st_q;
        st_d.underrun = in_ready && !in_valid;
        underrun      = st_q.underrun;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a missed sample raises the flag in the next cycle.
    assert_underrun_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun)
        else $error("missing underrun pulse");

    // R7: the flag never rises without a missed sample just before.
    assert_underrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(in_ready && !in_valid))
        else $error("spurious underrun pulse");

    // R8: both lanes read zero right after a ratio change.
    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (out_i == '0 && out_q == '0))
        else $error("outputs not cleared after a ratio change");

endmodule

// File: tb/duc_interp_chain_test.sv
module duc_interp_chain_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic signed [31:0] ratio;
        logic signed [31:0] xi;
        logic signed [31:0] xq;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{32'sd4,   32'sd1000,   -32'sd1000},
        '{32'sd5,   32'sd300,    -32'sd7},
        '{32'sd6,   -32'sd2000,  32'sd1234},
        '{32'sd8,   32'sd5000,   -32'sd5000},
        '{32'sd11,  32'sd12345,  -32'sd1},
        '{32'sd100, -32'sd3333,  32'sd777},
        '{32'sd130, 32'sd20000,  -32'sd15000},
        '{32'sd512, -32'sd9000,  32'sd4321},
        '{32'sd511, 32'sd16000,  -32'sd2500}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  ratio = 10'd4;
    logic        in_valid = 1'b1;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        in_ready, underrun;
    logic signed [15:0] out_i, out_q;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    duc_interp_chain uut (
        .clk(clk), .rst_n(rst_n), .ratio(ratio), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .in_ready(in_ready), .underrun(underrun),
        .out_i(out_i), .out_q(out_q)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff_ratio(input int r);
        if (r < 4)   return 4;
        if (r > 512) return 512;
        return r;
    endfunction

    function automatic string mode_tag(input int r);
        if (r % 2 == 1) return "R3";
        if (r % 4 == 2) return "R4";
        return "R5";
    endfunction

    function automatic longint exp_out(input longint x, input int r);
        longint rc, cube, v;
        int s;
        rc = (r % 2 == 1) ? r : ((r % 4 == 2) ? r / 2 : r / 4);
        cube = rc * rc * rc;
        s = 0;
        while ((longint'(1) << s) < cube) s++;
        v = (x * cube) >>> s;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    // R1: distance between two consecutive input strobes.
    task automatic measure_spacing(input int exp, input string tag);
        int n;
        int guard;
        guard = 0;
        @(negedge clk);
        while (!in_ready && guard < 2048) begin
            @(negedge clk);
            guard++;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!in_ready && n < 2048);
        check(tag, n, exp);
    endtask

    initial begin
        int prev_eff;
        int mism;
        int pulses;
        bit prev_hit;

        // R9: reset state
        repeat (4) @(negedge clk);
        check("R9 out_i in reset", out_i, 0);
        check("R9 out_q in reset", out_q, 0);
        check("R9 underrun in reset", underrun, 0);
        rst_n = 1'b1;

        // Table-driven DC gain and mode selection
        prev_eff = 4;
        for (int v = 0; v < 9; v++) begin
            int r;
            r = int'(VECS[v].ratio);
            @(negedge clk);
            ratio = 10'(r);
            in_i  = 16'(VECS[v].xi);
            in_q  = 16'(VECS[v].xq);
            if (eff_ratio(r) != prev_eff) begin
                @(negedge clk);
                check("R8 out_i after ratio change", out_i, 0);
                check("R8 out_q after ratio change", out_q, 0);
            end
            prev_eff = eff_ratio(r);
            repeat (30 * r + 50) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                check($sformatf("R6/%s out_i ratio %0d", mode_tag(r), r),
                      out_i, exp_out(longint'(VECS[v].xi), r));
                check($sformatf("R6/%s out_q ratio %0d", mode_tag(r), r),
                      out_q, exp_out(longint'(VECS[v].xq), r));
                repeat (k + 1) @(negedge clk);
            end
        end

        // R1: strobe spacing for each path variant
        ratio = 10'd5;
        measure_spacing(5, "R1 spacing ratio 5");
        ratio = 10'd6;
        measure_spacing(6, "R1 spacing ratio 6");
        ratio = 10'd4;
        measure_spacing(4, "R1 spacing ratio 4");

        // R2: out-of-range ratios
        ratio = 10'd2;
        measure_spacing(4, "R2 ratio 2 acts as 4");
        ratio = 10'd1000;
        measure_spacing(512, "R2 ratio 1000 acts as 512");
        ratio = 10'd0;
        measure_spacing(4, "R2 ratio 0 acts as 4");

        // R7: underrun behaviour
        @(negedge clk);
        ratio    = 10'd6;
        in_i     = 16'sd700;
        in_q     = -16'sd700;
        in_valid = 1'b1;
        repeat (250) @(negedge clk);
        pulses = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (underrun) pulses++;
        end
        check("R7 no underrun while data is valid", pulses, 0);

        in_valid = 1'b0;
        #1;
        prev_hit = in_ready;
        mism = 0;
        pulses = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            #1;
            if (underrun != prev_hit) mism++;
            if (underrun) pulses++;
            prev_hit = in_ready;
        end
        check("R7 underrun follows each missed strobe", mism, 0);
        check("R7 underrun pulse count", pulses, 10);
        repeat (250) @(negedge clk);
        check("R7 zeros fed out_i", out_i, 0);
        check("R7 zeros fed out_q", out_q, 0);
        in_valid = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule